// File: doc/BRIEF.md
# Maskable Interrupt Pulse and Flag Unit

This block gathers condition inputs from neighbouring logic (fault levels such as supply over-voltage, battery over-current or temperature zones, and single-cycle event strobes) and turns them into host-visible state plus one active-low interrupt line. Each source has a registered live status bit and a sticky flag. A per-source edge detector decides when a condition counts as a new event. The event always sets the flag, and it also requests an interrupt pulse unless that source is masked.

The interrupt line idles released (high) and is driven low for a fixed number of clock cycles per pulse. The length is derived from the clock frequency and a microsecond parameter. Events that arrive while a pulse or its trailing gap is running are remembered and produce one further full-length pulse once the gap is over. Nothing is reported until the start-up qualifier is high, and conditions already present at that point never produce an event. Register read logic clears flags through per-source strobes. Sources selected by a parameter refuse to clear while their condition is still present.

Top module: `intp_top`

## Requirements
- R1: During and straight after reset, `intN` is 1 (released), and every `statusOut` and `flagOut` bit is 0.
- R2: `statusOut[i]` equals the value `condIn[i]` had at the previous rising clock edge.
- R3: For a source whose bit in `BOTH_EDGE_MASK` is 0, a 0-to-1 change of `condIn[i]` sets `flagOut[i]` at the edge that samples it. A 1-to-0 change sets nothing and sends no pulse.
- R4: For a source whose bit in `BOTH_EDGE_MASK` is 1, both the 0-to-1 and the 1-to-0 change of `condIn[i]` count as events. Each one sets the flag and, if unmasked, requests a pulse.
- R5: An unmasked event pulls `intN` to 0 at the clock edge that samples it, when no pulse or gap is in progress. `intN` then stays 0 for exactly `PULSE_CYC = (CLK_HZ/1_000_000)*PULSE_US` cycles.
- R6: While `maskIn[i]` is 1, an event on source i still sets `flagOut[i]` but produces no pulse.
- R7: Clearing `maskIn[i]` to 0 while `condIn[i]` is still 1 produces no pulse. The next event on that source does produce one.
- R8: While `startupDone` is 0, no event is detected: no flag is set and `intN` stays 1. A condition that is already 1 when `startupDone` rises is not an event.
- R9: For a source whose bit in `HOLD_MASK` is 1, `rdClr[i]` clears the flag only if `statusOut[i]` is 0 at that edge. The flag never clears on its own when the condition goes away.
- R10: For other sources, `rdClr[i]` clears `flagOut[i]` at the next edge. If an event on the same source arrives at that edge, the flag stays set.
- R11: Events arriving during a pulse or its gap are merged into one pending request. After the pulse ends, `intN` stays 1 for exactly `GAP_CYC` cycles, and then the pending pulse starts with full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startupDone | input | 1 | High once start-up has reached a valid state; enables event detection |
| condIn | input | NUM_SRC | Condition levels and event strobes, one per source |
| maskIn | input | NUM_SRC | Per-source interrupt mask, 1 = masked |
| rdClr | input | NUM_SRC | Per-source flag clear strobe from register read logic |
| statusOut | output | NUM_SRC | Registered live status per source |
| flagOut | output | NUM_SRC | Sticky event flag per source |
| intN | output | 1 | Active-low interrupt pulse, 1 = released |

## Verification
The assertions assume two things about the inputs. First, `startupDone` never falls again once it has risen. Second, conditions are already synchronous to `clk`. Because of these assumptions, a low `startupDone` implies that no pulse has ever started, and each status change maps to exactly one sampled edge. The stimulus raises `startupDone` once and never lowers it. It changes every input one time unit after a rising edge, so each change is sampled by exactly one edge. The sweep walks every source through rise and fall with the mask both clear and set. It then probes unmasking during an active condition, reads that collide with events, and events stacked inside a running pulse.

// File: rtl/intp_pkg.sv
package intp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2
  } pulseState_t;

  // Strobes from the pulse control to the datapath
  typedef struct packed {
    logic consume;   // a pulse starts at this edge: drop the pending request
  } ctlStrb_t;

endpackage

// File: rtl/intp_edge.sv
module intp_edge #(
  parameter bit BOTH_EDGE   = 1'b0,
  parameter bit HOLD_ACTIVE = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateOpen,
  input  logic condIn,
  input  logic maskIn,
  input  logic rdClr,
  output logic status,
  output logic flag,
  output logic fire
);

  logic condQ;
  logic flagQ;
  logic trig;
  logic clrOk;

  generate
    if (BOTH_EDGE) begin : gBoth
      always_comb trig = gateOpen & (condIn ^ condQ);
    end else begin : gRise
      always_comb trig = gateOpen & condIn & ~condQ;
    end
  endgenerate

  // a hold source refuses to clear while the registered condition is active
  always_comb clrOk = rdClr & ~(HOLD_ACTIVE & condQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condQ <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      condQ <= condIn;
      if (trig) begin
        flagQ <= 1'b1;
      end else if (clrOk) begin
        flagQ <= 1'b0;
      end
    end
  end

  assign status = condQ;
  assign flag   = flagQ;
  assign fire   = trig & ~maskIn;

endmodule

// File: rtl/intp_datapath.sv
module intp_datapath
  import intp_pkg::*;
#(
  parameter int                  NUM_SRC        = 8,
  parameter logic [NUM_SRC-1:0]  BOTH_EDGE_MASK = '0,
  parameter logic [NUM_SRC-1:0]  HOLD_MASK      = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startupDone,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic [NUM_SRC-1:0] maskIn,
  input  logic [NUM_SRC-1:0] rdClr,
  input  ctlStrb_t           strb,
  output logic [NUM_SRC-1:0] statusOut,
  output logic [NUM_SRC-1:0] flagOut,
  output logic               reqPulse
);

  logic [NUM_SRC-1:0] fireVec;
  logic               pendQ;
  logic               anyFire;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
      intp_edge #(
        .BOTH_EDGE  (BOTH_EDGE_MASK[i]),
        .HOLD_ACTIVE(HOLD_MASK[i])
      ) uEdge (
        .clk     (clk),
        .rstN    (rstN),
        .gateOpen(startupDone),
        .condIn  (condIn[i]),
        .maskIn  (maskIn[i]),
        .rdClr   (rdClr[i]),
        .status  (statusOut[i]),
        .flag    (flagOut[i]),
        .fire    (fireVec[i])
      );
    end
  endgenerate

  assign anyFire  = |fireVec;
  assign reqPulse = pendQ | anyFire;

  // one pending bit: any number of events during a pulse merge into one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (strb.consume) begin
      pendQ <= 1'b0;
    end else if (anyFire) begin
      pendQ <= 1'b1;
    end
  end

endmodule

// File: rtl/intp_ctrl.sv
module intp_ctrl
  import intp_pkg::*;
#(
  parameter int PULSE_CYC = 12800,
  parameter int GAP_CYC   = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqPulse,
  output ctlStrb_t strb,
  output logic     intN
);

  localparam int MAX_CYC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GAP_LOAD   = CW'(GAP_CYC - 1);

  pulseState_t   state;
  logic [CW-1:0] cnt;
  logic          intNQ;
  logic          startNow;
  logic          cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    startNow = 1'b0;
    case (state)
      ST_IDLE: startNow = reqPulse;
      ST_GAP:  startNow = cntDone & reqPulse;
      default: startNow = 1'b0;
    endcase
  end

  always_comb strb.consume = startNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      intNQ <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state <= ST_PULSE;
            cnt   <= PULSE_LOAD;
            intNQ <= 1'b0;
          end
        end
        ST_PULSE: begin
          if (cntDone) begin
            state <= ST_GAP;
            cnt   <= GAP_LOAD;
            intNQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cntDone) begin
            if (startNow) begin
              state <= ST_PULSE;
              cnt   <= PULSE_LOAD;
              intNQ <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          intNQ <= 1'b1;
        end
      endcase
    end
  end

  assign intN = intNQ;

endmodule

// File: rtl/intp_top.sv
module intp_top
  import intp_pkg::*;
#(
  parameter int                 NUM_SRC        = 8,
  parameter logic [NUM_SRC-1:0] BOTH_EDGE_MASK = 8'b0000_0010,
  parameter logic [NUM_SRC-1:0] HOLD_MASK      = 8'b0000_0001,
  parameter int                 CLK_HZ         = 100_000_000,
  parameter int                 PULSE_US       = 128,
  parameter int                 GAP_CYC        = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startupDone,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic [NUM_SRC-1:0] maskIn,
  input  logic [NUM_SRC-1:0] rdClr,
  output logic [NUM_SRC-1:0] statusOut,
  output logic [NUM_SRC-1:0] flagOut,
  output logic               intN
);

  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;

  ctlStrb_t strb;
  logic     reqPulse;

  intp_datapath #(
    .NUM_SRC       (NUM_SRC),
    .BOTH_EDGE_MASK(BOTH_EDGE_MASK),
    .HOLD_MASK     (HOLD_MASK)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .startupDone(startupDone),
    .condIn     (condIn),
    .maskIn     (maskIn),
    .rdClr      (rdClr),
    .strb       (strb),
    .statusOut  (statusOut),
    .flagOut    (flagOut),
    .reqPulse   (reqPulse)
  );

  intp_ctrl #(
    .PULSE_CYC(PULSE_CYC),
    .GAP_CYC  (GAP_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqPulse(reqPulse),
    .strb    (strb),
    .intN    (intN)
  );

endmodule

// File: rtl/intp_checker.sv
module intp_checker #(
  parameter int                 NUM_SRC        = 8,
  parameter logic [NUM_SRC-1:0] BOTH_EDGE_MASK = '0,
  parameter logic [NUM_SRC-1:0] HOLD_MASK      = '0,
  parameter int                 PULSE_CYC      = 2,
  parameter int                 GAP_CYC        = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               startupDone,
  input logic [NUM_SRC-1:0] rdClr,
  input logic [NUM_SRC-1:0] statusOut,
  input logic [NUM_SRC-1:0] flagOut,
  input logic               intN
);

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    !startupDone |=> intN); // R8

  generate
    if (PULSE_CYC > 1) begin : gPulseLen
      AST_PULSE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
        $fell(intN) |=> !intN); // R5
    end
    if (GAP_CYC > 1) begin : gGapLen
      AST_GAP_NOT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
        $rose(intN) |=> intN); // R11
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
      AST_FLAG_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flagOut[i]) |-> $past(startupDone)); // R8

      AST_FLAG_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
        $fell(flagOut[i]) |-> $past(rdClr[i])); // R10

      AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(statusOut[i]) && $past(startupDone)) |-> flagOut[i]); // R3

      if (BOTH_EDGE_MASK[i]) begin : gBoth
        AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
          ($fell(statusOut[i]) && $past(startupDone)) |-> flagOut[i]); // R4
      end

      if (HOLD_MASK[i]) begin : gHold
        AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
          (flagOut[i] && statusOut[i]) |=> flagOut[i]); // R9
      end
    end
  endgenerate

endmodule

bind intp_top intp_checker #(
  .NUM_SRC       (NUM_SRC),
  .BOTH_EDGE_MASK(BOTH_EDGE_MASK),
  .HOLD_MASK     (HOLD_MASK),
  .PULSE_CYC     (PULSE_CYC),
  .GAP_CYC       (GAP_CYC)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startupDone(startupDone),
  .rdClr      (rdClr),
  .statusOut  (statusOut),
  .flagOut    (flagOut),
  .intN       (intN)
);

// File: tb/intp_top_test.sv
`timescale 1ns/1ps
module intp_top_test;

  localparam int N = 4;
  localparam logic [N-1:0] BOTH = 4'b0010;
  localparam logic [N-1:0] HOLD = 4'b0001;
  localparam int P = 6;   // CLK_HZ 1 MHz * 6 us
  localparam int G = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startupDone = 1'b0;
  logic [N-1:0] condIn = '0;
  logic [N-1:0] maskIn = '0;
  logic [N-1:0] rdClr = '0;
  logic [N-1:0] statusOut;
  logic [N-1:0] flagOut;
  logic         intN;

  int tests = 0;
  int fails = 0;
  int falls = 0;
  int lowRun = 0;
  int highRun = 0;
  int lastLowLen = 0;
  int lastHighLen = 0;
  int cycles = 0;
  logic prevN = 1'b1;

  always #2.5 clk = ~clk;

  intp_top #(
    .NUM_SRC(N), .BOTH_EDGE_MASK(BOTH), .HOLD_MASK(HOLD),
    .CLK_HZ(1_000_000), .PULSE_US(P), .GAP_CYC(G)
  ) uut (
    .clk(clk), .rstN(rstN), .startupDone(startupDone), .condIn(condIn),
    .maskIn(maskIn), .rdClr(rdClr), .statusOut(statusOut),
    .flagOut(flagOut), .intN(intN)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!intN) begin
      if (prevN) begin
        falls++;
        lastHighLen = highRun;
        lowRun = 0;
      end
      lowRun++;
    end else begin
      if (!prevN) begin
        lastLowLen = lowRun;
        highRun = 0;
      end
      highRun++;
    end
    prevN = intN;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic readClr(input logic [N-1:0] sel);
    rdClr = sel;
    tick();
    rdClr = '0;
  endtask

  int f0;

  initial begin
    tick(4);
    chk("R1 intN in reset", int'(intN), 1);
    chk("R1 flags in reset", int'(flagOut), 0);
    rstN = 1'b1;
    tick();
    chk("R1 intN after reset", int'(intN), 1);
    chk("R1 status after reset", int'(statusOut), 0);

    // R8: events before start-up are invisible
    condIn = 4'b0100;
    tick();
    chk("R2 status follows cond", int'(statusOut), 4);
    tick(3);
    chk("R8 no flag before start", int'(flagOut), 0);
    startupDone = 1'b1;
    tick(20);
    chk("R8 no flag from pre-start level", int'(flagOut), 0);
    chk("R8 no pulse from pre-start level", falls, 0);
    condIn = '0;
    tick(20);
    chk("R3 fall of rising source ignored", int'(flagOut), 0);
    chk("R3 no pulse on fall", falls, 0);

    // sweep: every source, mask clear and set
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        maskIn = (m == 1) ? (4'b0001 << i) : '0;
        f0 = falls;
        condIn[i] = 1'b1;
        tick(20);
        chk(BOTH[i] ? "R4 rise sets flag" : "R3 rise sets flag", int'(flagOut[i]), 1);
        chk(m == 1 ? "R6 masked rise no pulse" : "R3 rise pulse count", falls - f0, m == 1 ? 0 : 1);
        f0 = falls;
        condIn[i] = 1'b0;
        tick(20);
        chk(BOTH[i] ? "R4 fall pulse count" : "R3 fall pulse count", falls - f0,
            (m == 0 && BOTH[i]) ? 1 : 0);
        chk("R10 flag sticky until read", int'(flagOut[i]), 1);
        readClr(4'b0001 << i);
        chk(HOLD[i] ? "R9 clears once inactive" : "R10 read clears", int'(flagOut[i]), 0);
      end
    end
    maskIn = '0;
    chk("R5 pulse length", lastLowLen, P);

    // R5: exact start and end of the pulse
    condIn[3] = 1'b1;
    tick();
    chk("R5 low at sampling edge", int'(intN), 0);
    tick(5);
    chk("R5 still low at last cycle", int'(intN), 0);
    tick();
    chk("R5 released after length", int'(intN), 1);
    tick(10);
    condIn[3] = 1'b0;
    tick(2);
    readClr(4'b1000);

    // R6/R7: masked event, then unmask while active
    maskIn[2] = 1'b1;
    f0 = falls;
    condIn[2] = 1'b1;
    tick(20);
    chk("R6 masked flag set", int'(flagOut[2]), 1);
    maskIn[2] = 1'b0;
    tick(20);
    chk("R7 no catch-up pulse", falls - f0, 0);
    condIn[2] = 1'b0;
    tick(3);
    condIn[2] = 1'b1;
    tick(20);
    chk("R7 new edge after unmask pulses", falls - f0, 1);
    condIn[2] = 1'b0;
    tick(2);
    readClr(4'b0100);

    // R9: hold source refuses to clear while active
    condIn[0] = 1'b1;
    tick(20);
    readClr(4'b0001);
    chk("R9 read ignored while active", int'(flagOut[0]), 1);
    condIn[0] = 1'b0;
    tick(3);
    chk("R9 no self clear", int'(flagOut[0]), 1);
    readClr(4'b0001);
    chk("R9 read clears after gone", int'(flagOut[0]), 0);

    // R10: event wins over a same-edge read
    condIn[3] = 1'b1;
    rdClr[3] = 1'b1;
    tick();
    rdClr = '0;
    chk("R10 set wins over clear", int'(flagOut[3]), 1);
    tick(20);
    condIn[3] = 1'b0;
    tick(2);
    readClr(4'b1000);
    chk("R10 plain read clears", int'(flagOut[3]), 0);

    // R11: events during a pulse merge into one further pulse
    f0 = falls;
    condIn[2] = 1'b1;
    tick(3);
    condIn[3] = 1'b1;
    tick();
    condIn[1] = 1'b1;
    tick(30);
    chk("R11 merged pulse count", falls - f0, 2);
    chk("R11 gap length", lastHighLen, G);
    chk("R11 second pulse full length", lastLowLen, P);
    chk("R11 flags of merged events", int'(flagOut), 14);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule